// File: doc/BRIEF.md
# Selective Hit-Channel Readout Serializer

This block gathers one measurement record per front-end channel and, on request, shifts out only the channels that saw a trigger during the current acquisition. A free-running coarse timer counts in Gray code. By default it steps once every four clock cycles, which is 100 ns at a 40 MHz clock. When a channel's trigger input rises for the first time in an acquisition, the channel captures the Gray value together with a flag. The flag tells whether the timer rolled over since the acquisition was started. The converter writes each channel's charge word and fine-time word into a small record store. Each word carries a flag that names the gain path or the ramp that produced it.

A readout request starts a scan in ascending channel order. Every hit channel is emitted as one fixed-length record on a serial data line, most significant bit first, with a valid strobe. Channels without a hit add no bits and no cycles. After the last bit, a one-cycle done pulse is raised and all hit flags are cleared. The parameters set the channel count, the timer width, the converter width and the tick divider. The default configuration gives a 51-bit record: 4 bits of channel, 25 bits of coarse time, 11 bits of charge and 11 bits of fine time.

Top module: `hitReadoutSerializer`

## Requirements
- R1: After reset, serValid and readDone are low, no channel is hit, the coarse timer holds 0, the wrap flag is 0 and every stored charge and fine-time field is 0.
- R2: A readout emits records only for hit channels, in ascending channel number. An unhit channel contributes no bits, and a readout with h hit channels carries exactly h×REC_W valid bits.
- R3: Each record is REC_W = log2(NUM_CH) + CT_W + 1 + 2×(ADC_W+1) bits and is sent MSB first. Its fields, from the top, are: channel number, wrap flag, Gray coarse time, gain flag, charge value, ramp flag, fine-time value.
- R4: A channel's coarse field holds the Gray code of the timer as it stood at the clock edge that saw the channel's trigger input go from 0 to 1. Later rising edges in the same acquisition leave it unchanged.
- R5: The binary timer starts at 0 after reset and increments once every TICK_DIV cycles, wrapping modulo 2^CT_W. The Gray value is bin XOR (bin >> 1).
- R6: The wrap flag in a record is 1 exactly when the timer rolled from all ones to zero between the last acqStart and the trigger capture.
- R7: A conversion write (convWrEn high for one cycle) stores the gain flag, charge, ramp flag and fine time for convCh. A later write to the same channel replaces the earlier one.
- R8: readDone is high for exactly one cycle, in the cycle right after the last valid bit. If no channel is hit, it is high in the cycle after the request edge.
- R9: While a readout is running, further readReq pulses and trigger edges have no effect on the stream or on the hit flags.
- R10: Hit flags are cleared when a readout ends, so a second readout without new triggers carries no bits.
- R11: Each record occupies REC_W+1 cycles, which is one load cycle plus REC_W bit cycles. A full readout of all NUM_CH channels finishes within BUDGET_CYC cycles.
- R12: acqStart clears all hit flags and the wrap flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| acqStart | input | 1 | Begin a new acquisition: clear hits and wrap flag |
| trigIn | input | NUM_CH | Per-channel trigger levels |
| convWrEn | input | 1 | Store a conversion result |
| convCh | input | log2(NUM_CH) | Channel of the conversion result |
| convCharge | input | ADC_W | Charge value |
| convGainSel | input | 1 | Gain path used for the charge |
| convFine | input | ADC_W | Fine-time value |
| convRampSel | input | 1 | Ramp used for the fine time |
| readReq | input | 1 | Start a readout |
| serData | output | 1 | Serial record data, MSB first |
| serValid | output | 1 | serData carries a record bit |
| readDone | output | 1 | One-cycle end-of-readout pulse |

## Verification
The hardest situations to reach from the ports are a capture taken after the Gray timer has rolled over, and stray requests or triggers arriving in the middle of a stream. The bench is built with a 5-bit timer and a divider of 2, so the timer rolls over every 64 cycles and can be placed before or after a trigger by waiting. A reference timer in the bench is stepped from the same edges to predict each capture. During one long all-channel readout the bench fires an extra request and triggers on channels that are not hit. It then checks that the stream is unchanged and that the next readout is empty.

// File: rtl/hitReadoutPkg.sv
package hitReadoutPkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_LOAD,
    SEQ_SHIFT,
    SEQ_DONE
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic busy;
    logic loadRec;
    logic shiftEn;
    logic clearHits;
  } seqStrobe_t;

endpackage

// File: rtl/grayTimer.sv
module grayTimer #(
  parameter int CT_W     = 24,
  parameter int TICK_DIV = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            acqStart,
  output logic [CT_W-1:0] grayVal,
  output logic            wrapSeen
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0] divCnt;
  logic [CT_W-1:0]  binCnt;
  logic             tick;

  assign tick = (divCnt == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      binCnt   <= '0;
      wrapSeen <= 1'b0;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) binCnt <= binCnt + 1'b1;
      if (acqStart)               wrapSeen <= 1'b0;
      else if (tick && &binCnt)   wrapSeen <= 1'b1;
    end
  end

  assign grayVal = binCnt ^ (binCnt >> 1);

  // R5: consecutive Gray values differ in at most one bit
  a_r5_gray_single_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($countones(grayVal ^ $past(grayVal)) <= 1));

endmodule

// File: rtl/hitDatapath.sv
module hitDatapath
  import hitReadoutPkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  parameter int CT_W   = 24,
  parameter int ADC_W  = 10,
  parameter int REC_W  = 51
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              acqStart,
  input  logic [NUM_CH-1:0] trigIn,
  input  logic              convWrEn,
  input  logic [CH_W-1:0]   convCh,
  input  logic [ADC_W-1:0]  convCharge,
  input  logic              convGainSel,
  input  logic [ADC_W-1:0]  convFine,
  input  logic              convRampSel,
  input  logic [CT_W-1:0]   grayVal,
  input  logic              wrapSeen,
  input  seqStrobe_t        strobe,
  input  logic [CH_W-1:0]   chSel,
  output logic [NUM_CH-1:0] hitFlags,
  output logic              serData
);
  localparam int CT_F   = CT_W + 1;
  localparam int MEAS_W = 2 * (ADC_W + 1);

  logic [NUM_CH-1:0] trigPrev;
  logic [NUM_CH-1:0] captVec;
  logic [CT_F-1:0]   coarseMem [NUM_CH];
  logic [MEAS_W-1:0] measMem   [NUM_CH];
  logic [REC_W-1:0]  shiftReg;

  assign captVec = trigIn & ~trigPrev & ~hitFlags & {NUM_CH{~strobe.busy}};

  always_ff @(posedge clk) begin
    if (!rstN) trigPrev <= '0;
    else       trigPrev <= trigIn;
  end

  // hit flags and coarse capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitFlags <= '0;
      for (int i = 0; i < NUM_CH; i++) coarseMem[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (acqStart || strobe.clearHits) begin
          hitFlags[i] <= 1'b0;
        end else if (captVec[i]) begin
          hitFlags[i]  <= 1'b1;
          coarseMem[i] <= {wrapSeen, grayVal};
        end
      end
    end
  end

  // conversion record store
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) measMem[i] <= '0;
    end else if (convWrEn) begin
      for (int i = 0; i < NUM_CH; i++)
        if (convCh == CH_W'(i))
          measMem[i] <= {convGainSel, convCharge, convRampSel, convFine};
    end
  end

  // output shifter
  always_ff @(posedge clk) begin
    if (!rstN)               shiftReg <= '0;
    else if (strobe.loadRec) shiftReg <= {chSel, coarseMem[chSel], measMem[chSel]};
    else if (strobe.shiftEn) shiftReg <= {shiftReg[REC_W-2:0], 1'b0};
  end

  assign serData = shiftReg[REC_W-1];

  // R2: the sequencer only loads channels that are flagged as hit
  a_r2_load_hit_only: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadRec |-> hitFlags[chSel]);

  // R4: a captured coarse time is held while the channel stays hit
  for (genvar g = 0; g < NUM_CH; g++) begin : gHold
    a_r4_coarse_held: assert property (@(posedge clk) disable iff (!rstN)
      (hitFlags[g] && $past(hitFlags[g])) |-> $stable(coarseMem[g]));
  end

endmodule

// File: rtl/hitSequencer.sv
module hitSequencer
  import hitReadoutPkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int CH_W       = 4,
  parameter int REC_W      = 51,
  parameter int BUDGET_CYC = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readReq,
  input  logic [NUM_CH-1:0] hitFlags,
  output seqStrobe_t        strobe,
  output logic [CH_W-1:0]   chSel,
  output logic              readDone
);
  localparam int BIT_W = $clog2(REC_W);
  localparam int CNT_W = $clog2(BUDGET_CYC + 2);

  seqState_t         state;
  logic [NUM_CH-1:0] pending;
  logic [BIT_W-1:0]  bitCnt;
  logic              lastBit;
  logic [CNT_W-1:0]  busyCnt;

  function automatic logic [CH_W-1:0] pickLowest(input logic [NUM_CH-1:0] m);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (m[i]) r = CH_W'(i);
    return r;
  endfunction

  assign chSel   = pickLowest(pending);
  assign lastBit = (bitCnt == BIT_W'(REC_W - 1));

  always_comb begin
    strobe.busy      = (state != SEQ_IDLE);
    strobe.loadRec   = (state == SEQ_LOAD);
    strobe.shiftEn   = (state == SEQ_SHIFT);
    strobe.clearHits = (state == SEQ_DONE);
  end

  assign readDone = (state == SEQ_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      pending <= '0;
      bitCnt  <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (readReq) begin
          if (|hitFlags) begin
            pending <= hitFlags;
            state   <= SEQ_LOAD;
          end else begin
            state <= SEQ_DONE;
          end
        end
        SEQ_LOAD: begin
          pending <= pending & ~(NUM_CH'(1) << chSel);
          bitCnt  <= '0;
          state   <= SEQ_SHIFT;
        end
        SEQ_SHIFT: begin
          if (lastBit) state <= (|pending) ? SEQ_LOAD : SEQ_DONE;
          else         bitCnt <= bitCnt + 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // cycles spent in the current readout, for the budget check
  always_ff @(posedge clk) begin
    if (!rstN || state == SEQ_IDLE)                busyCnt <= '0;
    else if (busyCnt != CNT_W'(BUDGET_CYC + 1))    busyCnt <= busyCnt + 1'b1;
  end

  // R11: a readout never exceeds the cycle budget
  a_r11_budget: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= CNT_W'(BUDGET_CYC));

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    readDone |=> !readDone);

  // R10: after done, the datapath reports no hit channel
  a_r10_hits_cleared: assert property (@(posedge clk) disable iff (!rstN)
    readDone |=> (hitFlags == '0));

  // R9: a request in mid-record does not disturb the shift
  a_r9_req_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftEn && readReq && !lastBit) |=> strobe.shiftEn);

endmodule

// File: rtl/hitReadoutSerializer.sv
module hitReadoutSerializer
  import hitReadoutPkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int CT_W       = 24,
  parameter int ADC_W      = 10,
  parameter int TICK_DIV   = 4,
  parameter int BUDGET_CYC = 1000,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int REC_W     = CH_W + CT_W + 1 + 2 * (ADC_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              acqStart,
  input  logic [NUM_CH-1:0] trigIn,
  input  logic              convWrEn,
  input  logic [CH_W-1:0]   convCh,
  input  logic [ADC_W-1:0]  convCharge,
  input  logic              convGainSel,
  input  logic [ADC_W-1:0]  convFine,
  input  logic              convRampSel,
  input  logic              readReq,
  output logic              serData,
  output logic              serValid,
  output logic              readDone
);
  logic [CT_W-1:0]   grayVal;
  logic              wrapSeen;
  logic [NUM_CH-1:0] hitFlags;
  logic [CH_W-1:0]   chSel;
  seqStrobe_t        strobe;

  grayTimer #(.CT_W(CT_W), .TICK_DIV(TICK_DIV)) uTimer (
    .clk(clk), .rstN(rstN), .acqStart(acqStart),
    .grayVal(grayVal), .wrapSeen(wrapSeen)
  );

  hitDatapath #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .CT_W(CT_W), .ADC_W(ADC_W), .REC_W(REC_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .acqStart(acqStart), .trigIn(trigIn),
    .convWrEn(convWrEn), .convCh(convCh), .convCharge(convCharge),
    .convGainSel(convGainSel), .convFine(convFine), .convRampSel(convRampSel),
    .grayVal(grayVal), .wrapSeen(wrapSeen), .strobe(strobe), .chSel(chSel),
    .hitFlags(hitFlags), .serData(serData)
  );

  hitSequencer #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .REC_W(REC_W), .BUDGET_CYC(BUDGET_CYC)
  ) uSeq (
    .clk(clk), .rstN(rstN), .readReq(readReq), .hitFlags(hitFlags),
    .strobe(strobe), .chSel(chSel), .readDone(readDone)
  );

  assign serValid = strobe.shiftEn;

endmodule

// File: tb/hitReadoutSerializer_test.sv
`timescale 1ns/1ps
module hitReadoutSerializer_test;
  localparam int NCH = 16;
  localparam int CHW = 4;
  localparam int CTW = 5;
  localparam int AW  = 10;
  localparam int TD  = 2;
  localparam int RW  = CHW + CTW + 1 + 2 * (AW + 1);

  logic clk = 1'b0, rstN = 1'b0, acqStart = 1'b0, readReq = 1'b0;
  logic convWrEn = 1'b0, convGainSel = 1'b0, convRampSel = 1'b0;
  logic [NCH-1:0] trigIn = '0;
  logic [CHW-1:0] convCh = '0;
  logic [AW-1:0]  convCharge = '0, convFine = '0;
  wire serData, serValid, readDone;

  hitReadoutSerializer #(.NUM_CH(NCH), .CT_W(CTW), .ADC_W(AW), .TICK_DIV(TD)) uut (
    .clk(clk), .rstN(rstN), .acqStart(acqStart), .trigIn(trigIn),
    .convWrEn(convWrEn), .convCh(convCh), .convCharge(convCharge),
    .convGainSel(convGainSel), .convFine(convFine), .convRampSel(convRampSel),
    .readReq(readReq), .serData(serData), .serValid(serValid), .readDone(readDone)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference timer built from R5 and R6
  int mDiv = 0;
  logic [CTW-1:0] mBin = '0;
  logic mWrap = 1'b0;
  always @(posedge clk) begin
    if (!rstN) begin
      mDiv <= 0; mBin <= '0; mWrap <= 1'b0;
    end else begin
      if (mDiv == TD - 1) begin mDiv <= 0; mBin <= mBin + 1'b1; end
      else mDiv <= mDiv + 1;
      if (acqStart) mWrap <= 1'b0;
      else if (mDiv == TD - 1 && mBin == {CTW{1'b1}}) mWrap <= 1'b1;
    end
  end

  logic [CTW:0]      expCoarse [NCH];
  logic [2*AW+1:0]   expMeas   [NCH];
  logic [NCH-1:0]    expHit = '0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic startAcq();
    @(negedge clk); acqStart = 1'b1; expHit = '0;
    @(negedge clk); acqStart = 1'b0;
  endtask

  task automatic writeConv(input int ch, input int chg, input bit g, input int fn, input bit r);
    @(negedge clk);
    convWrEn = 1'b1; convCh = CHW'(ch); convCharge = AW'(chg); convGainSel = g;
    convFine = AW'(fn); convRampSel = r;
    expMeas[ch] = {g, AW'(chg), r, AW'(fn)};
    @(negedge clk); convWrEn = 1'b0;
  endtask

  task automatic trigPulse(input logic [NCH-1:0] mask);
    @(negedge clk);
    for (int i = 0; i < NCH; i++)
      if (mask[i] && !expHit[i]) begin
        expCoarse[i] = {mWrap, mBin ^ (mBin >> 1)};
        expHit[i] = 1'b1;
      end
    trigIn = mask;
    @(negedge clk); trigIn = '0;
  endtask

  task automatic readout(input string tag, input bit disturb);
    bit got [$];
    int idx, lastValid, doneIdx, nHit, k;
    logic [RW-1:0] expRec, actRec;
    logic [NCH-1:0] stray;
    nHit = $countones(expHit);
    stray = ~expHit;
    lastValid = 0; doneIdx = 0;
    @(negedge clk); readReq = 1'b1;
    @(negedge clk); readReq = 1'b0;
    idx = 1;
    while (idx < 3000) begin
      if (serValid) begin got.push_back(serData); lastValid = idx; end
      if (readDone) begin doneIdx = idx; break; end
      if (disturb && idx == 5) begin readReq = 1'b1; trigIn = stray; end
      else if (disturb && idx == 6) begin readReq = 1'b0; trigIn = '0; end
      @(negedge clk);
      idx++;
    end
    // R2: bit count; R8 and R11: done position
    check(got.size() == nHit * RW, {tag, " R2 bit count"}, got.size(), nHit * RW);
    check(doneIdx == nHit * (RW + 1) + 1, {tag, " R8 R11 done cycle"}, doneIdx, nHit * (RW + 1) + 1);
    if (nHit > 0)
      check(doneIdx == lastValid + 1, {tag, " R8 done after last bit"}, doneIdx, lastValid + 1);
    @(negedge clk);
    check(readDone == 1'b0, {tag, " R8 single pulse"}, readDone, 0);
    // R3: records in ascending channel order
    k = 0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (expHit[ch] && got.size() >= (k + 1) * RW) begin
        expRec = {CHW'(ch), expCoarse[ch], expMeas[ch]};
        for (int j = 0; j < RW; j++) actRec[RW-1-j] = got[k*RW + j];
        check(actRec == expRec, {tag, " R3 record"}, actRec, expRec);
        k++;
      end
    end
    expHit = '0; // R10
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin expCoarse[i] = '0; expMeas[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1: quiet outputs after reset, empty first readout
    check(serValid == 1'b0, "R1 serValid", serValid, 0);
    check(readDone == 1'b0, "R1 readDone", readDone, 0);
    readout("R1 empty", 1'b0);
    // R1 R5: immediate trigger sees an early timer value, zero fields
    trigPulse(16'h0001);
    readout("R1 R5 early", 1'b0);

    // sweep: each channel alone (R2 R3 R4 R5 R7), then empty repeat (R10)
    for (int ch = 0; ch < NCH; ch++) begin
      startAcq();
      writeConv(ch, (ch * 37 + 5) % 1024, ch[0], (ch * 91 + 3) % 1024, ch[1]);
      repeat (ch * 3) @(negedge clk);
      trigPulse(NCH'(1) << ch);
      readout("R2 R4 R5 single", 1'b0);
      readout("R10 repeat", 1'b0);
    end

    // all channels, staggered triggers, disturbed readout (R9 R11)
    startAcq();
    for (int ch = 0; ch < NCH; ch++)
      writeConv(ch, 1023 - ch * 11, ~ch[0], ch * 60, ch[2]);
    for (int ch = 0; ch < NCH; ch += 2) begin
      trigPulse(NCH'(3) << ch);
      repeat (ch) @(negedge clk);
    end
    readout("R9 R11 full", 1'b1);
    readout("R9 R10 after full", 1'b0);

    // wrap flag and retrigger (R6 R4), last write wins (R7)
    startAcq();
    trigPulse(16'h0004);
    writeConv(9, 100, 1'b0, 200, 1'b0);
    writeConv(9, 777, 1'b1, 555, 1'b1);
    repeat (70) @(negedge clk);
    check(mWrap == 1'b1, "R6 model wrapped", mWrap, 1);
    trigPulse(16'h0204);
    repeat (9) @(negedge clk);
    trigPulse(16'hA5C3 & ~16'h0204);
    readout("R4 R6 R7 pattern", 1'b0);

    // R12: acqStart discards hits
    trigPulse(16'h00F0);
    startAcq();
    readout("R12 cleared", 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule